// File: doc/BRIEF.md
# Serial ADC Sample Capture Controller

This block is the master side of a serial link to an analog-to-digital converter that delivers one sample per conversion as a continuous bit stream. Every flip-flop in it runs on the single system clock. A free-running divider produces two one-cycle strobes, one just ahead of each rising and each falling edge of the serial clock. The serial clock pin is a registered output that follows those strobes, so no logic is ever clocked by a derived or gated clock.

A start request from the surrounding logic makes the controller raise the converter enable. It then lets a fixed number of serial-clock cycles pass and shifts in one unbroken word, most significant bit first. Outgoing signals (the enable and the rising serial-clock edge) change only on the rising-edge strobe. Incoming data is sampled only on the falling-edge strobe. The finished word appears on a parallel output with a single-cycle valid pulse, and a busy flag covers the whole transaction.

The divide ratio has to be chosen from the system clock rate so that the serial clock stays at or below 2.9 MHz. With the default half-period of 8 system cycles, this holds for any system clock up to 46.4 MHz.

Top module: `adc_spi_capture`

## Requirements
- R1: The serial clock has a period of exactly 2*HALF_DIV system cycles (16 by default), 50 % duty, and changes level only in a cycle that follows a rising or falling strobe.
- R2: The serial clock is low whenever the converter enable is low, including in idle.
- R3: The converter enable changes level only at a rising-edge strobe.
- R4: The serial clock rises together with the enable. After that first rise come WAIT_CYCLES (5) further rises before the first data sample. The final sample follows rise number WAIT_CYCLES+FRAME_BITS-1 (20) after the first rise. No further rise occurs before the enable drops.
- R5: The word is captured MSB first as FRAME_BITS (16) contiguous samples, one on each falling edge from the first sample onward, with no gap between any two bits.
- R6: After the last sample, data_o carries the captured word and valid_o is high for exactly one system cycle.
- R7: busy_o rises in the cycle after an accepted start and stays high until the enable has been released. A start seen while busy_o is high, including one in the cycle of the valid pulse, starts no transaction.
- R8: A synchronous active-high reset leaves the serial clock low, the enable low, busy_o low and valid_o low in the following cycle, and no word is delivered for an interrupted frame.
- R9: data_o changes only in a cycle where valid_o is high, and otherwise holds the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock in the block |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request for one conversion; taken while idle |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Registered serial clock, parked low |
| conv_en_o | output | 1 | Converter enable, active high |
| busy_o | output | 1 | Transaction in progress |
| data_o | output | FRAME_BITS | Last captured sample |
| valid_o | output | 1 | One-cycle pulse when data_o is updated |

## Verification
A new start request can coincide with the end of a frame: the cycle that delivers the valid pulse is also a cycle in which start_i may be high while busy_o is still set. The bench provokes this in two ways. It holds start_i high through the end of a frame, which must yield exactly one further back-to-back frame once the enable has been released. It also pulses start_i alone in the valid cycle, after which busy_o must stay low. A scoreboard judges both cases by the number and content of delivered words, and a converter model in the bench checks the count of serial-clock rises per frame.

// File: rtl/adc_spi_capture_pkg.sv
package adc_spi_capture_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  // true when a counter at value cur has reached the last step of a span of n
  function automatic logic at_last(input int unsigned cur, input int unsigned n);
    return (cur == n - 1);
  endfunction

  // modulo-n increment used by all wrapping counters
  function automatic int unsigned step_mod(input int unsigned cur, input int unsigned n);
    return (cur == n - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/adc_spi_edge_gen.sv
module adc_spi_edge_gen #(
  parameter int unsigned HALF_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic rise_stb,
  output logic fall_stb
);
  import adc_spi_capture_pkg::*;

  localparam int unsigned DCW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

  logic [DCW-1:0] div_q;
  logic           phase_q;
  logic           wrap;

  assign wrap     = at_last(int'(div_q), HALF_DIV);
  assign rise_stb = wrap & ~phase_q;
  assign fall_stb = wrap &  phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      div_q <= DCW'(step_mod(int'(div_q), HALF_DIV));
      if (wrap) phase_q <= ~phase_q;
    end
  end
endmodule

// File: rtl/adc_spi_sequencer.sv
module adc_spi_sequencer #(
  parameter int unsigned WAIT_CYCLES = 5,
  parameter int unsigned FRAME_BITS  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic rise_stb,
  input  logic fall_stb,
  output logic conv_en,
  output logic sclk,
  output logic busy,
  output logic sample_take,
  output logic frame_last
);
  import adc_spi_capture_pkg::*;

  localparam int unsigned WCW = $clog2(WAIT_CYCLES + 1);
  localparam int unsigned BCW = $clog2(FRAME_BITS + 1);

  seq_state_e     state_q, state_n;
  logic           en_q, en_n;
  logic           sclk_q;
  logic [WCW-1:0] wcnt_q, wcnt_n;
  logic [BCW-1:0] bcnt_q, bcnt_n;

  always_comb begin
    state_n     = state_q;
    en_n        = en_q;
    wcnt_n      = wcnt_q;
    bcnt_n      = bcnt_q;
    sample_take = 1'b0;
    frame_last  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (rise_stb) begin
          if (!en_q) begin
            en_n   = 1'b1;
            wcnt_n = '0;
          end else if (at_last(int'(wcnt_q), WAIT_CYCLES)) begin
            state_n = ST_SHIFT;
            bcnt_n  = '0;
          end else begin
            wcnt_n = wcnt_q + 1'b1;
          end
        end
      end
      ST_SHIFT: begin
        if (fall_stb) begin
          sample_take = 1'b1;
          if (at_last(int'(bcnt_q), FRAME_BITS)) begin
            frame_last = 1'b1;
            state_n    = ST_DONE;
          end else begin
            bcnt_n = bcnt_q + 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (rise_stb) begin
          en_n    = 1'b0;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      sclk_q  <= 1'b0;
      wcnt_q  <= '0;
      bcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      en_q    <= en_n;
      wcnt_q  <= wcnt_n;
      bcnt_q  <= bcnt_n;
      if (rise_stb)      sclk_q <= en_n;
      else if (fall_stb) sclk_q <= 1'b0;
    end
  end

  assign conv_en = en_q;
  assign sclk    = sclk_q;
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/adc_spi_shifter.sv
module adc_spi_shifter #(
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sample_take,
  input  logic                  frame_last,
  input  logic                  miso,
  output logic [FRAME_BITS-1:0] data,
  output logic                  valid
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [FRAME_BITS-1:0] sh_n;
  logic [FRAME_BITS-1:0] out_q;
  logic                  vld_q;

  assign sh_n = {sh_q[FRAME_BITS-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (sample_take) sh_q <= sh_n;
      if (sample_take && frame_last) begin
        out_q <= sh_n;
        vld_q <= 1'b1;
      end
    end
  end

  assign data  = out_q;
  assign valid = vld_q;
endmodule

// File: rtl/adc_spi_capture.sv
module adc_spi_capture #(
  parameter int unsigned HALF_DIV    = 8,
  parameter int unsigned WAIT_CYCLES = 5,
  parameter int unsigned FRAME_BITS  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  miso_i,
  output logic                  sclk_o,
  output logic                  conv_en_o,
  output logic                  busy_o,
  output logic [FRAME_BITS-1:0] data_o,
  output logic                  valid_o
);
  logic rise_stb;
  logic fall_stb;
  logic sample_take;
  logic frame_last;

  adc_spi_edge_gen #(.HALF_DIV(HALF_DIV)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  adc_spi_sequencer #(.WAIT_CYCLES(WAIT_CYCLES), .FRAME_BITS(FRAME_BITS)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start_i),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb),
    .conv_en     (conv_en_o),
    .sclk        (sclk_o),
    .busy        (busy_o),
    .sample_take (sample_take),
    .frame_last  (frame_last)
  );

  adc_spi_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .sample_take (sample_take),
    .frame_last  (frame_last),
    .miso        (miso_i),
    .data        (data_o),
    .valid       (valid_o)
  );
endmodule

// File: rtl/adc_spi_capture_chk.sv
module adc_spi_capture_chk #(
  parameter int unsigned FRAME_BITS = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  rise_stb,
  input logic                  fall_stb,
  input logic                  sclk,
  input logic                  conv_en,
  input logic                  busy,
  input logic                  valid,
  input logic [FRAME_BITS-1:0] data
);
  p_sclk_on_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sclk) && $past(!rst)) |-> $past(rise_stb || fall_stb));

  p_sclk_parked_r2: assert property (@(posedge clk) disable iff (rst)
    !conv_en |-> !sclk);

  p_enable_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(conv_en) && $past(!rst)) |-> $past(rise_stb));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_enable_within_busy_r7: assert property (@(posedge clk) disable iff (rst)
    conv_en |-> busy);

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (!sclk && !conv_en && !busy && !valid));

  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$stable(data) && $past(!rst)) |-> valid);
endmodule

bind adc_spi_capture adc_spi_capture_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb),
  .sclk     (sclk_o),
  .conv_en  (conv_en_o),
  .busy     (busy_o),
  .valid    (valid_o),
  .data     (data_o)
);

// File: tb/adc_spi_capture_test.sv
module adc_spi_capture_test;
  localparam int HALF  = 8;
  localparam int WAITC = 5;
  localparam int BITS  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic miso = 1'b0;
  logic sclk, conv_en, busy, valid;
  logic [BITS-1:0] data;

  always #5 clk = ~clk;

  adc_spi_capture #(.HALF_DIV(HALF), .WAIT_CYCLES(WAITC), .FRAME_BITS(BITS)) uut (
    .clk(clk), .rst(rst), .start_i(start), .miso_i(miso),
    .sclk_o(sclk), .conv_en_o(conv_en), .busy_o(busy),
    .data_o(data), .valid_o(valid)
  );

  int checks = 0;
  int errors = 0;
  logic [BITS-1:0] exp_q[$];
  logic [BITS-1:0] adc_word = '0;
  int valid_count = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model: presents bits after sclk rises, counts rises per frame
  int     r = -1;
  int     rises_last = -1;
  int     bad_period = 0;
  logic   prev_s = 1'b0, prev_e = 1'b0;
  longint cyc = 0, last_rise = 0;
  always @(posedge clk) begin
    cyc++;
    #1;
    if (sclk && !prev_s) begin
      if (!prev_e) r = 0;
      else begin
        r++;
        if (cyc - last_rise != 2 * HALF) bad_period++;
      end
      last_rise = cyc;
      if (r >= WAITC && r - WAITC < BITS) miso = adc_word[BITS-1-(r-WAITC)];
      else miso = 1'b0;
    end
    if (!conv_en && prev_e) rises_last = r;
    prev_s = sclk;
    prev_e = conv_en;
  end

  // scoreboard monitor
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (valid && !rst) begin
      valid_count++;
      // R6: pulse lasts one cycle
      check(!prev_valid, "R6", "valid longer than one cycle", 1, 0);
      if (exp_q.size() == 0) check(1'b0, "R7", "unexpected word", data, 0);
      else begin
        logic [BITS-1:0] e;
        e = exp_q.pop_front();
        check(data == e, "R5", "captured word", data, e);
      end
    end
    prev_valid = valid;
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic run_frame(input logic [BITS-1:0] w);
    adc_word = w;
    exp_q.push_back(w);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", busy, 1);
    wait_idle();
    check(rises_last == WAITC + BITS - 1, "R4", "sclk rises after first", rises_last, WAITC + BITS - 1);
    check(exp_q.size() == 0, "R6", "word delivered", exp_q.size(), 0);
    check(sclk == 1'b0 && conv_en == 1'b0, "R2", "idle sclk/enable", {sclk, conv_en}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(sclk == 0, "R8", "sclk after reset", sclk, 0);
    check(conv_en == 0, "R8", "enable after reset", conv_en, 0);
    check(busy == 0, "R8", "busy after reset", busy, 0);
    check(valid == 0 && data == 0, "R8", "output after reset", data, 0);
    repeat (40) @(negedge clk);
    check(sclk == 0, "R2", "sclk parked in idle", sclk, 0);

    run_frame(16'hA5C3);
    run_frame(16'h8001);
    run_frame(16'hFFFF);
    run_frame(16'h0000);
    run_frame(16'h7FFE);

    // R9: data held in idle
    repeat (50) @(negedge clk);
    check(data == 16'h7FFE, "R9", "data held", data, 16'h7FFE);

    // R7: start while busy is ignored
    vc = valid_count;
    adc_word = 16'h3C5A;
    exp_q.push_back(16'h3C5A);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R7", "busy during frame", busy, 1);
    wait_idle();
    repeat (40) @(negedge clk);
    check(valid_count == vc + 1, "R7", "words for ignored start", valid_count - vc, 1);
    check(busy == 1'b0, "R7", "idle after frame", busy, 0);

    // R7: start pulse in the valid cycle only
    vc = valid_count;
    adc_word = 16'h1234;
    exp_q.push_back(16'h1234);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    do @(negedge clk); while (!valid);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_idle();
    repeat (40) @(negedge clk);
    check(busy == 1'b0, "R7", "start in valid cycle ignored", busy, 0);
    check(valid_count == vc + 1, "R7", "words for valid-cycle start", valid_count - vc, 1);

    // start held across frame end: exactly one more frame
    vc = valid_count;
    adc_word = 16'hC0DE;
    exp_q.push_back(16'hC0DE);
    exp_q.push_back(16'h0F0F);
    @(negedge clk) start = 1'b1;
    do @(negedge clk); while (!valid);
    adc_word = 16'h0F0F;
    @(negedge clk);
    do @(negedge clk); while (!valid);
    start = 1'b0;
    wait_idle();
    repeat (40) @(negedge clk);
    check(valid_count == vc + 2, "R7", "back-to-back words", valid_count - vc, 2);
    check(exp_q.size() == 0, "R5", "back-to-back queue empty", exp_q.size(), 0);

    // R8: reset in mid-frame
    vc = valid_count;
    adc_word = 16'hDEAD;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (200) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!sclk && !conv_en && !busy && !valid, "R8", "mid-frame reset",
          {sclk, conv_en, busy, valid}, 0);
    rst = 1'b0;
    repeat (400) @(negedge clk);
    check(valid_count == vc, "R8", "no word after reset", valid_count - vc, 0);

    run_frame(16'h5AA5);
    check(bad_period == 0, "R1", "sclk period violations", bad_period, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule